// File: doc/BRIEF.md
# Double-Buffered Serial Code Latch

This block is the digital front end of a serially loaded converter. A three-wire serial link delivers a code one bit at a time into a shift stage: a data line, a serial clock and a load strobe. A second register holds the code that is presented to the converter. Because the two registers are separate, a new code can be shifted in while the converter keeps the old one. The new code is released only when the load strobe falls. An active-low clear forces the presented code to zero and takes priority over the load strobe.

All external lines are asynchronous to the system clock. Each one passes through a two-flop synchroniser. The serial clock, the load strobe and the clear each get their edges detected on the system clock. The code width is a parameter. It is 12 by default, and a 10-bit build is the intended alternative. The presented code is a registered parallel bus. A one-cycle pulse marks every change of that bus.

Top module: `serial_code_latch`

## Requirements
- R1: With the load strobe high, each rising edge of the serial clock shifts the data line into the shift stage, and the first bit sent ends up as the most significant bit of the code.
- R2: Exactly WIDTH serial clock rising edges, followed by a load fall, present the WIDTH bits just sent as the code.
- R3: When more than WIDTH bits are sent, only the last WIDTH bits are kept. For example, a 16-bit transfer presents its low WIDTH bits.
- R4: Serial clock edges that occur while the load strobe is low change nothing in the shift stage.
- R5: A falling edge of the load strobe copies the shift stage into the presented code, provided clear is high.
- R6: Shifting new bits without a load fall leaves the presented code unchanged.
- R7: While clear is low, the presented code is all zeros, and a load fall during that time does not transfer anything.
- R8: When clear returns high while the load strobe is low, the shift stage is copied into the presented code at once.
- R9: Clear does not alter the shift stage. A load fall after clear has been released presents the bits that were shifted before the clear.
- R10: After system reset, the presented code is zero, the update pulse is low, and the shift stage holds zero.
- R11: The update pulse is high for exactly one cycle in the same cycle as each change of the presented code. A transfer that leaves the value the same gives no pulse.
- R12: The presented code changes on the third system clock rising edge after the load strobe falls. Each serial clock phase must last at least two system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| ser_dat_i | input | 1 | Serial data line, asynchronous |
| ser_clk_i | input | 1 | Serial clock, asynchronous, sampled on rising edge |
| load_i | input | 1 | Load strobe, asynchronous; gates the serial clock when low, transfers on fall |
| clear_n_i | input | 1 | Active-low clear of the presented code, asynchronous |
| code_o | output | WIDTH | Presented converter code |
| code_upd_o | output | 1 | One-cycle pulse when code_o changes |

## Verification
On every cycle, the assertions check the following. The code is zero one cycle after clear is seen low. The code holds still unless a load fall or a clear release is detected. A detected load fall with clear high lands the shift stage in the code. The shift stage never moves while load is seen low. The update pulse marks a code change exactly. Some behaviours appear only in the bench scenarios, which drive the real serial lines: MSB-first bit order, keeping the last WIDTH bits of an over-long transfer, survival of the shift stage across a clear, and the three-edge latency from a load fall.

// File: rtl/scl_pkg.sv
// Shared types for the serial code latch.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package scl_pkg;

    // Source of the next value of the presented code register.
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_ZERO  = 2'd1,
        SRC_SHIFT = 2'd2
    } code_src_t;

    // Bit positions of the control lines inside the synchroniser vector.
    localparam int unsigned CTL_SCLK  = 0;
    localparam int unsigned CTL_LOAD  = 1;
    localparam int unsigned CTL_CLEAR = 2;
    localparam int unsigned CTL_DATA  = 3;
    localparam int unsigned CTL_LINES = 4;

endpackage

// File: rtl/scl_in_sync.sv
// Two-flop synchroniser for a vector of asynchronous lines.
// Does: brings each bit of async_i into the clk domain with two flops.
// Assumes: each line is stable for at least two clk cycles between changes;
//          RST_VAL gives the idle level of each line, which avoids false edges after reset.
module scl_in_sync #(
    parameter int unsigned N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    logic [N-1:0] meta_q;

    // Two-stage capture of the asynchronous lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_o <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end

endmodule

// File: rtl/scl_edge_tap.sv
// One-cycle delay of synchronised control lines, used for edge detection.
// Does: keeps the previous cycle's value of each line so the parent can compare.
// Assumes: lvl_i is already in the clk domain.
module scl_edge_tap #(
    parameter int unsigned N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] prev_o
);

    // Delay each synchronised line by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_o <= RST_VAL;
        else        prev_o <= lvl_i;
    end

endmodule

// File: rtl/scl_shift_stage.sv
// MSB-first input shift register.
// Does: on shift_i, moves the register up one place and inserts bit_i at the LSB,
//       so older bits fall off the top and the last WIDTH bits remain.
// Assumes: shift_i is a single-cycle strobe, already gated by the load level.
module scl_shift_stage #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] word_o
);

    // Shift one bit in at each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_o <= '0;
        else if (shift_i) word_o <= {word_o[WIDTH-2:0], bit_i};
    end

endmodule

// File: rtl/scl_code_reg.sv
// Presented-code register with clear priority and change pulse.
// Does: holds the converter code. Clear low forces zero. A load fall, or a clear
//       release seen while load is low, copies the shift word. upd_o pulses
//       in the cycle the stored value differs from the one before.
// Assumes: all controls are synchronised single-domain signals.
module scl_code_reg
    import scl_pkg::*;
#(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_lvl_i,
    input  logic             clr_rise_i,
    input  logic             ld_lvl_i,
    input  logic             ld_fall_i,
    input  logic [WIDTH-1:0] word_i,
    output logic [WIDTH-1:0] code_o,
    output logic             upd_o
);

    code_src_t        src;
    logic [WIDTH-1:0] code_nx;

    // Choose the source of the next code; clear outranks every transfer.
    always_comb begin
        if (!clr_lvl_i)                              src = SRC_ZERO;
        else if (ld_fall_i || (clr_rise_i && !ld_lvl_i)) src = SRC_SHIFT;
        else                                         src = SRC_HOLD;
    end

    // Next-value mux for the code register.
    always_comb begin
        unique case (src)
            SRC_ZERO:  code_nx = '0;
            SRC_SHIFT: code_nx = word_i;
            default:   code_nx = code_o;
        endcase
    end

    // Store the code and flag any change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
            upd_o  <= 1'b0;
        end else begin
            code_o <= code_nx;
            upd_o  <= (code_nx != code_o);
        end
    end

endmodule

// File: rtl/serial_code_latch.sv
// Double-buffered serial code latch, top level.
// Does: synchronises the serial lines, shifts data on gated serial clock rises,
//       and transfers to the presented code on load fall or clear release.
// Assumes: serial clock high and low phases each last at least two clk cycles;
//          the data line is stable around each serial clock rise.
module serial_code_latch
    import scl_pkg::*;
#(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_dat_i,
    input  logic             ser_clk_i,
    input  logic             load_i,
    input  logic             clear_n_i,
    output logic [WIDTH-1:0] code_o,
    output logic             code_upd_o
);

    localparam int unsigned NCTL = CTL_LINES - 1;
    // Idle levels: data 0, clear high, load high, serial clock low.
    localparam logic [CTL_LINES-1:0] IDLE_ALL = 4'b0110;
    localparam logic [NCTL-1:0]      IDLE_CTL = IDLE_ALL[NCTL-1:0];

    logic [CTL_LINES-1:0] raw_lines;
    logic [CTL_LINES-1:0] lvl;
    logic [NCTL-1:0]      prev;
    logic                 sclk_rise;
    logic                 ld_lvl;
    logic                 ld_fall;
    logic                 clr_lvl;
    logic                 clr_rise;
    logic                 shift_en;
    logic [WIDTH-1:0]     shift_word;

    // Pack the raw lines in synchroniser order.
    always_comb begin
        raw_lines             = '0;
        raw_lines[CTL_SCLK]  = ser_clk_i;
        raw_lines[CTL_LOAD]  = load_i;
        raw_lines[CTL_CLEAR] = clear_n_i;
        raw_lines[CTL_DATA]  = ser_dat_i;
    end

    scl_in_sync #(.N(CTL_LINES), .RST_VAL(IDLE_ALL)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_lines),
        .sync_o (lvl)
    );

    scl_edge_tap #(.N(NCTL), .RST_VAL(IDLE_CTL)) u_tap (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (lvl[NCTL-1:0]),
        .prev_o(prev)
    );

    // Edge decode and serial clock gating by the load level.
    always_comb begin
        ld_lvl    = lvl[CTL_LOAD];
        clr_lvl   = lvl[CTL_CLEAR];
        sclk_rise = lvl[CTL_SCLK] & ~prev[CTL_SCLK];
        ld_fall   = ~lvl[CTL_LOAD] & prev[CTL_LOAD];
        clr_rise  = lvl[CTL_CLEAR] & ~prev[CTL_CLEAR];
        shift_en  = sclk_rise & ld_lvl;
    end

    scl_shift_stage #(.WIDTH(WIDTH)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift_i(shift_en),
        .bit_i  (lvl[CTL_DATA]),
        .word_o (shift_word)
    );

    scl_code_reg #(.WIDTH(WIDTH)) u_code (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_lvl_i (clr_lvl),
        .clr_rise_i(clr_rise),
        .ld_lvl_i  (ld_lvl),
        .ld_fall_i (ld_fall),
        .word_i    (shift_word),
        .code_o    (code_o),
        .upd_o     (code_upd_o)
    );

endmodule

// File: rtl/serial_code_latch_chk.sv
// Assertion checker for serial_code_latch, attached by bind.
// Does: checks the clear, transfer, hold, gating and update-pulse rules each cycle.
// Assumes: it is bound to serial_code_latch and sees its decoded internal strobes.
module serial_code_latch_chk #(
    parameter int unsigned WIDTH = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_lvl,
    input logic             clr_rise,
    input logic             ld_lvl,
    input logic             ld_fall,
    input logic [WIDTH-1:0] shift_word,
    input logic [WIDTH-1:0] code_o,
    input logic             code_upd_o
);

    // R7: clear seen low gives a zero code on the next cycle.
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_lvl |=> (code_o == '0));

    // R6: with no transfer event and clear high, the code holds.
    a_r6_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lvl && !ld_fall && !clr_rise) |=> $stable(code_o));

    // R5: a load fall with clear high presents the shift word.
    a_r5_load_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lvl && ld_fall) |=> (code_o == $past(shift_word)));

    // R8: a clear release with load low presents the shift word.
    a_r8_release_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise && !ld_lvl) |=> (code_o == $past(shift_word)));

    // R4: the shift stage never moves while load is seen low.
    a_r4_gated_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_lvl |=> $stable(shift_word));

    // R11: the update pulse marks a code change and nothing else.
    a_r11_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        code_upd_o |-> (code_o != $past(code_o)));
    a_r11_change_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != $past(code_o)) |-> code_upd_o);

endmodule

bind serial_code_latch serial_code_latch_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_lvl   (clr_lvl),
    .clr_rise  (clr_rise),
    .ld_lvl    (ld_lvl),
    .ld_fall   (ld_fall),
    .shift_word(shift_word),
    .code_o    (code_o),
    .code_upd_o(code_upd_o)
);

// File: tb/serial_code_latch_test.sv
`timescale 1ns/1ps
module serial_code_latch_test;

    localparam int unsigned W    = 12;
    localparam logic [W-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sdat = 1'b0;
    logic         sclk = 1'b0;
    logic         load = 1'b1;
    logic         clr_n = 1'b1;
    logic [W-1:0] code;
    logic         upd;

    int n_tests = 0;
    int n_fail  = 0;
    int upd_cnt = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    serial_code_latch #(.WIDTH(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_dat_i (sdat),
        .ser_clk_i (sclk),
        .load_i    (load),
        .clear_n_i (clr_n),
        .code_o    (code),
        .code_upd_o(upd)
    );

    // Count update pulses seen at each rising edge.
    always @(posedge clk) if (rst_n && upd) upd_cnt <= upd_cnt + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Send n bits of v, MSB first, at the fastest legal serial rate.
    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = v[i];
            sclk = 1'b0;
            cyc(2);
            sclk = 1'b1;
            cyc(2);
        end
        sclk = 1'b0;
        cyc(4);
    endtask

    task automatic load_pulse;
        load = 1'b0;
        cyc(6);
        load = 1'b1;
        cyc(4);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] prev_code;
        int           cnt0;
        cyc(4);
        // R10: reset state
        check("R10 code", code, 0);
        check("R10 upd", upd, 0);
        rst_n = 1'b1;
        cyc(4);
        check("R10 code after release", code, 0);
        load_pulse();
        check("R10 shift zero", code, 0);

        // R1/R2/R5/R11: sweep of codes with distinct patterns
        prev_code = '0;
        for (int k = 0; k < 80; k++) begin
            logic [W-1:0] v;
            if (k < W)           v = W'(1) << k;
            else if (k == W)     v = MASK;
            else if (k == W + 1) v = '0;
            else                 v = W'((k * 1237 + 91) & MASK);
            send(v, W);
            check("R6 hold before load", code, prev_code);
            cnt0 = upd_cnt;
            load_pulse();
            check("R2 R1 R5 code after load", code, v);
            check("R11 pulse count", upd_cnt - cnt0, (v != prev_code) ? 1 : 0);
            prev_code = v;
        end

        // R11: same value again gives no pulse
        send(prev_code, W);
        cnt0 = upd_cnt;
        load_pulse();
        check("R11 no pulse same", upd_cnt - cnt0, 0);

        // R3: 16-bit transfer keeps low W bits
        send(32'hA5C3, 16);
        load_pulse();
        check("R3 last bits", code, 32'hA5C3 & MASK);
        send(32'h3FFFF, 18);
        send(32'h5, 3);
        load_pulse();
        check("R3 appended bits", code, ((32'h3FFFF << 3) | 5) & MASK);

        // R12: latency from load fall
        send(32'h123, W);
        load = 1'b0;
        cyc(2);
        check("R12 old after two edges", code, ((32'h3FFFF << 3) | 5) & MASK);
        cyc(1);
        check("R12 new after three edges", code, 32'h123);
        check("R12 R11 pulse same cycle", upd, 1);
        cyc(1);
        check("R11 pulse one cycle", upd, 0);
        cyc(3);

        // R4: serial clocks with load low are ignored (load is low now)
        send(32'hFFF, W);
        load = 1'b1;
        cyc(4);
        load_pulse();
        check("R4 gated clocks", code, 32'h123);

        // R7: clear forces zero and blocks a load fall
        send(32'h9AB, W);
        clr_n = 1'b0;
        cyc(4);
        check("R7 clear zero", code, 0);
        load_pulse();
        check("R7 load fall ignored", code, 0);

        // R9: clear released with load high, then load fall shows old shift word
        clr_n = 1'b1;
        cyc(4);
        check("R9 still zero", code, 0);
        load_pulse();
        check("R9 shift kept", code, 32'h9AB);

        // R8: release clear while load low transfers at once
        send(32'h456, W);
        clr_n = 1'b0;
        cyc(4);
        load = 1'b0;
        cyc(4);
        check("R8 zero under clear", code, 0);
        clr_n = 1'b1;
        cyc(4);
        check("R8 release transfer", code, 32'h456);
        load = 1'b1;
        cyc(4);
        check("R8 no change on load rise", code, 32'h456);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule